// File: doc/BRIEF.md
# Domain-to-Entry Range Resolver

The resolver turns the set of memory domains tied to a requester into the set of protection entries that requester must check. Each clock it takes a bitmap with one bit per domain and produces a registered mask with one bit per entry. A bit in the mask is set when the entry belongs to a selected domain.

A build-time parameter picks one of three partitioning schemes. In bounded mode each domain has a programmable upper bound, and the domains take consecutive slices of the entry array. In fixed-stride mode every domain owns a block of K entries and K is a constant. In programmable-stride mode K can be written until a global enable is raised. In bounded mode a prefix lock protects the low-numbered bound registers. Its prefix can only grow, and a sticky seal freezes it. Both stride modes leave the lock out.

Two tiny two-state machines hold the sticky seal and the global enable. Each one moves from OPEN to SHUT on transition SEAL and stays in SHUT until reset.

Top module: `dom_entry_resolver`

## Requirements
- R1: In bounded mode (MODE=0), domain 0 owns entries j < bound(0). Domain m>0 owns the entries j with max(bound(0..m-1)) <= j < bound(m).
- R2: In bounded mode a bound lower than an earlier domain's bound gives that domain no entries, and no entry is ever owned by two domains.
- R3: `own_mask` is the OR of the ranges of all domains whose `dom_map` bit is set. An all-zero map gives a zero mask. The mask is registered and reflects the map and the configuration present at the preceding rising edge.
- R4: In fixed-stride mode (MODE=1), domain m owns entries m*K to m*K+K-1, clipped to the entry count. `stride_m1` always reads K-1, and stride writes have no effect.
- R5: In programmable-stride mode (MODE=2), a write with `wr_kind`=1 loads k-1 from `wr_data[4:0]`, and domain m then owns entries m*k to m*k+k-1, clipped. The stride resets to K-1. Once `cfg_locked` is set, stride writes are ignored.
- R6: A write with `wr_kind`=3 and `wr_data[0]`=1 sets `cfg_locked`, which then stays set until reset.
- R7: In bounded mode a write with `wr_kind`=0 loads bound(`wr_dom`) from `wr_data[4:0]`, unless `wr_dom` < `lock_prefix`. In that case the write is ignored.
- R8: A write with `wr_kind`=2 replaces `lock_prefix` with `wr_data[2:0]` only when the new value is larger. A smaller or equal value is ignored.
- R9: A lock write with `wr_data[15]`=1 sets `lock_sealed`. That write still applies its prefix. After the seal is set, all lock writes are ignored.
- R10: In both stride modes the lock is absent. `lock_prefix` reads 0 and `lock_sealed` reads 0, and lock writes and bound writes change nothing.
- R11: After reset all bounds and the prefix are 0, both sticky bits are clear, the stride holds K-1, and `own_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dom_map | input | NUM_DOM | Domains associated with the requester |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 2 | 0 bound, 1 stride, 2 lock, 3 enable |
| wr_dom | input | DOM_W | Domain addressed by a bound write |
| wr_data | input | DATA_W | Write data |
| own_mask | output | NUM_ENT | Registered entry-ownership mask |
| stride_m1 | output | IDX_W | Current k-1 |
| lock_prefix | output | PFX_W | Lowest writable bound index |
| lock_sealed | output | 1 | Lock register frozen |
| cfg_locked | output | 1 | Global enable / stride lock |

## Verification
A configuration write lands on the rising edge that samples it, so `lock_prefix`, `lock_sealed`, `cfg_locked` and `stride_m1` are readable one cycle after the strobe. The mask takes one more register stage: it reflects a new map or a new configuration on the first edge after both are present. The driver presents each map and queues the expected mask, tagged with the cycle count of the next edge. The monitor compares that mask shortly after that edge, and the driver leaves configuration alone until the comparison is done.

// File: rtl/rr_pkg.sv
package rr_pkg;

    typedef enum logic [1:0] {
        WK_TOP    = 2'd0,
        WK_STRIDE = 2'd1,
        WK_LOCK   = 2'd2,
        WK_ENABLE = 2'd3
    } wr_kind_e;

    typedef enum logic {
        SEAL_OPEN = 1'b0,
        SEAL_SHUT = 1'b1
    } seal_state_e;

    localparam int MODE_TOP   = 0;
    localparam int MODE_FIXED = 1;
    localparam int MODE_PROG  = 2;

endpackage

// File: rtl/rr_seal_fsm.sv
// Sticky one-way latch written as a two-state machine: OPEN -> SHUT.
module rr_seal_fsm
    import rr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    output logic shut
);

    seal_state_e state_q;
    seal_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEAL_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEAL_OPEN: if (set_req) state_d = SEAL_SHUT;
            SEAL_SHUT: state_d = SEAL_SHUT;
            default:   state_d = SEAL_OPEN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SEAL_OPEN: shut = 1'b0;
            SEAL_SHUT: shut = 1'b1;
            default:   shut = 1'b0;
        endcase
    end

endmodule

// File: rtl/rr_cfg_regs.sv
// Bound registers, stride register, prefix lock and global enable.
module rr_cfg_regs
    import rr_pkg::*;
#(
    parameter int MODE    = MODE_TOP,
    parameter int NUM_DOM = 6,
    parameter int NUM_ENT = 24,
    parameter int FIX_K   = 4,
    parameter int DATA_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [1:0]                        wr_kind,
    input  logic [((NUM_DOM > 1) ? $clog2(NUM_DOM) : 1)-1:0] wr_dom,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NUM_DOM-1:0][$clog2(NUM_ENT+1)-1:0] tops,
    output logic [$clog2(NUM_ENT+1)-1:0]      stride_m1,
    output logic [$clog2(NUM_DOM+1)-1:0]      lock_prefix,
    output logic                              lock_sealed,
    output logic                              cfg_locked
);

    localparam int IDX_W = $clog2(NUM_ENT + 1);
    localparam int DOM_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
    localparam int PFX_W = $clog2(NUM_DOM + 1);

    wr_kind_e kind;
    logic     top_hit;
    logic     stride_hit;
    logic     lock_hit;
    logic     en_hit;
    logic     en_req;

    assign kind       = wr_kind_e'(wr_kind);
    assign top_hit    = wr_en && (kind == WK_TOP);
    assign stride_hit = wr_en && (kind == WK_STRIDE);
    assign lock_hit   = wr_en && (kind == WK_LOCK);
    assign en_hit     = wr_en && (kind == WK_ENABLE);
    assign en_req     = en_hit && wr_data[0];

    rr_seal_fsm u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (en_req),
        .shut    (cfg_locked)
    );

    if (MODE == MODE_TOP) begin : g_bounded
        logic [PFX_W-1:0] pfx_q;
        logic             seal_req;

        assign seal_req = lock_hit && wr_data[DATA_W-1];

        rr_seal_fsm u_seal (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (seal_req),
            .shut    (lock_sealed)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pfx_q <= '0;
            end else if (lock_hit && !lock_sealed &&
                         (wr_data[PFX_W-1:0] > pfx_q)) begin
                pfx_q <= wr_data[PFX_W-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tops <= '0;
            end else begin
                for (int m = 0; m < NUM_DOM; m++) begin
                    if (top_hit && (wr_dom == DOM_W'(m)) &&
                        (PFX_W'(m) >= pfx_q)) begin
                        tops[m] <= wr_data[IDX_W-1:0];
                    end
                end
            end
        end

        assign lock_prefix = pfx_q;
    end else begin : g_no_lock
        assign tops        = '0;
        assign lock_prefix = '0;
        assign lock_sealed = 1'b0;
    end

    if (MODE == MODE_PROG) begin : g_prog_stride
        logic [IDX_W-1:0] stride_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stride_q <= IDX_W'(FIX_K - 1);
            end else if (stride_hit && !cfg_locked) begin
                stride_q <= wr_data[IDX_W-1:0];
            end
        end
        assign stride_m1 = stride_q;
    end else begin : g_const_stride
        assign stride_m1 = IDX_W'(FIX_K - 1);
    end

    logic cfg_unused;
    assign cfg_unused = ^{wr_data, wr_dom, top_hit, stride_hit, lock_hit};

endmodule

// File: rtl/rr_bounds.sv
// Per-domain half-open range [lo, hi) for the selected partitioning mode.
module rr_bounds
    import rr_pkg::*;
#(
    parameter int MODE    = MODE_TOP,
    parameter int NUM_DOM = 6,
    parameter int NUM_ENT = 24,
    parameter int BW      = 12
) (
    input  logic [NUM_DOM-1:0][$clog2(NUM_ENT+1)-1:0] tops,
    input  logic [$clog2(NUM_ENT+1)-1:0]              stride_m1,
    output logic [NUM_DOM-1:0][BW-1:0]                lo,
    output logic [NUM_DOM-1:0][BW-1:0]                hi
);

    if (MODE == MODE_TOP) begin : g_top
        // Effective floor of each domain is the running maximum of earlier tops.
        always_comb begin
            logic [BW-1:0] run;
            run = '0;
            for (int m = 0; m < NUM_DOM; m++) begin
                lo[m] = run;
                hi[m] = BW'(tops[m]);
                if (BW'(tops[m]) > run) begin
                    run = BW'(tops[m]);
                end
            end
        end
    end else begin : g_stride
        logic [BW-1:0] k;
        assign k = BW'(stride_m1) + BW'(1);
        for (genvar m = 0; m < NUM_DOM; m++) begin : g_dom
            assign lo[m] = BW'(m) * k;
            assign hi[m] = (BW'(m) * k) + k;
        end
    end

    logic bnd_unused;
    assign bnd_unused = ^{tops, stride_m1};

endmodule

// File: rtl/rr_expand.sv
// Turns selected domain ranges into an entry mask.
module rr_expand #(
    parameter int NUM_DOM = 6,
    parameter int NUM_ENT = 24,
    parameter int BW      = 12
) (
    input  logic [NUM_DOM-1:0]          dom_map,
    input  logic [NUM_DOM-1:0][BW-1:0]  lo,
    input  logic [NUM_DOM-1:0][BW-1:0]  hi,
    output logic [NUM_ENT-1:0]          mask
);

    always_comb begin
        mask = '0;
        for (int m = 0; m < NUM_DOM; m++) begin
            for (int j = 0; j < NUM_ENT; j++) begin
                if (dom_map[m] && (BW'(j) >= lo[m]) && (BW'(j) < hi[m])) begin
                    mask[j] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dom_entry_resolver.sv
module dom_entry_resolver
    import rr_pkg::*;
#(
    parameter int MODE    = MODE_TOP,
    parameter int NUM_DOM = 6,
    parameter int NUM_ENT = 24,
    parameter int FIX_K   = 4,
    parameter int DATA_W  = 16
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_DOM-1:0]                        dom_map,
    input  logic                                      wr_en,
    input  logic [1:0]                                wr_kind,
    input  logic [((NUM_DOM > 1) ? $clog2(NUM_DOM) : 1)-1:0] wr_dom,
    input  logic [DATA_W-1:0]                         wr_data,
    output logic [NUM_ENT-1:0]                        own_mask,
    output logic [$clog2(NUM_ENT+1)-1:0]              stride_m1,
    output logic [$clog2(NUM_DOM+1)-1:0]              lock_prefix,
    output logic                                      lock_sealed,
    output logic                                      cfg_locked
);

    localparam int IDX_W = $clog2(NUM_ENT + 1);
    localparam int DOM_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
    localparam int BW    = DOM_W + IDX_W + 2;

    logic [NUM_DOM-1:0][IDX_W-1:0] tops;
    logic [NUM_DOM-1:0][BW-1:0]    lo;
    logic [NUM_DOM-1:0][BW-1:0]    hi;
    logic [NUM_ENT-1:0]            mask_c;

    rr_cfg_regs #(
        .MODE(MODE), .NUM_DOM(NUM_DOM), .NUM_ENT(NUM_ENT),
        .FIX_K(FIX_K), .DATA_W(DATA_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_kind     (wr_kind),
        .wr_dom      (wr_dom),
        .wr_data     (wr_data),
        .tops        (tops),
        .stride_m1   (stride_m1),
        .lock_prefix (lock_prefix),
        .lock_sealed (lock_sealed),
        .cfg_locked  (cfg_locked)
    );

    rr_bounds #(
        .MODE(MODE), .NUM_DOM(NUM_DOM), .NUM_ENT(NUM_ENT), .BW(BW)
    ) u_bounds (
        .tops      (tops),
        .stride_m1 (stride_m1),
        .lo        (lo),
        .hi        (hi)
    );

    rr_expand #(
        .NUM_DOM(NUM_DOM), .NUM_ENT(NUM_ENT), .BW(BW)
    ) u_expand (
        .dom_map (dom_map),
        .lo      (lo),
        .hi      (hi),
        .mask    (mask_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_mask <= '0;
        end else begin
            own_mask <= mask_c;
        end
    end

endmodule

// File: rtl/dom_entry_resolver_chk.sv
module dom_entry_resolver_chk #(
    parameter int MODE    = 0,
    parameter int NUM_DOM = 6,
    parameter int NUM_ENT = 24,
    parameter int FIX_K   = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_DOM-1:0]            dom_map,
    input logic                          wr_en,
    input logic [NUM_ENT-1:0]            own_mask,
    input logic [$clog2(NUM_ENT+1)-1:0]  stride_m1,
    input logic [$clog2(NUM_DOM+1)-1:0]  lock_prefix,
    input logic                          lock_sealed,
    input logic                          cfg_locked
);

    assert_empty_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_map == '0) |=> (own_mask == '0));

    assert_prefix_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lock_prefix >= $past(lock_prefix)));

    assert_prefix_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(lock_prefix));

    assert_seal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_sealed |=> (lock_sealed && $stable(lock_prefix)));

    assert_enable_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> cfg_locked);

    assert_stride_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> $stable(stride_m1));

    if (MODE != 2) begin : g_fixed
        assert_stride_const_R4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> $stable(stride_m1));
    end

    if (MODE != 0) begin : g_nolock
        assert_no_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> ((lock_prefix == '0) && !lock_sealed));
    end

endmodule

bind dom_entry_resolver dom_entry_resolver_chk #(
    .MODE(MODE), .NUM_DOM(NUM_DOM), .NUM_ENT(NUM_ENT), .FIX_K(FIX_K)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dom_map     (dom_map),
    .wr_en       (wr_en),
    .own_mask    (own_mask),
    .stride_m1   (stride_m1),
    .lock_prefix (lock_prefix),
    .lock_sealed (lock_sealed),
    .cfg_locked  (cfg_locked)
);

// File: tb/tb_dom_entry_resolver.sv
`timescale 1ns/1ps
module tb_dom_entry_resolver;

    localparam int ND = 6;
    localparam int NE = 24;

    typedef struct {
        int          sel;
        logic [23:0] exp;
        string       tag;
        int          due;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  map_s  [3];
    logic        we_s   [3];
    logic [1:0]  kind_s [3];
    logic [2:0]  dom_s  [3];
    logic [15:0] data_s [3];
    logic [23:0] mask_s [3];
    logic [4:0]  strd_s [3];
    logic [2:0]  pfx_s  [3];
    logic        seal_s [3];
    logic        lck_s  [3];

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    item_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dom_entry_resolver #(.MODE(0)) dut (
        .clk(clk), .rst_n(rst_n), .dom_map(map_s[0]), .wr_en(we_s[0]),
        .wr_kind(kind_s[0]), .wr_dom(dom_s[0]), .wr_data(data_s[0]),
        .own_mask(mask_s[0]), .stride_m1(strd_s[0]), .lock_prefix(pfx_s[0]),
        .lock_sealed(seal_s[0]), .cfg_locked(lck_s[0]));

    dom_entry_resolver #(.MODE(1)) dut_fix (
        .clk(clk), .rst_n(rst_n), .dom_map(map_s[1]), .wr_en(we_s[1]),
        .wr_kind(kind_s[1]), .wr_dom(dom_s[1]), .wr_data(data_s[1]),
        .own_mask(mask_s[1]), .stride_m1(strd_s[1]), .lock_prefix(pfx_s[1]),
        .lock_sealed(seal_s[1]), .cfg_locked(lck_s[1]));

    dom_entry_resolver #(.MODE(2)) dut_prg (
        .clk(clk), .rst_n(rst_n), .dom_map(map_s[2]), .wr_en(we_s[2]),
        .wr_kind(kind_s[2]), .wr_dom(dom_s[2]), .wr_data(data_s[2]),
        .own_mask(mask_s[2]), .stride_m1(strd_s[2]), .lock_prefix(pfx_s[2]),
        .lock_sealed(seal_s[2]), .cfg_locked(lck_s[2]));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int s, input int kind, input int dom, input int data);
        @(negedge clk);
        we_s[s]   = 1'b1;
        kind_s[s] = 2'(kind);
        dom_s[s]  = 3'(dom);
        data_s[s] = 16'(data);
        @(negedge clk);
        we_s[s]   = 1'b0;
    endtask

    // Driver: present a map and queue the mask due on the next edge.
    task automatic probe(input int s, input logic [5:0] m, input logic [23:0] e, input string tag);
        item_t it;
        @(negedge clk);
        map_s[s] = m;
        it.sel = s;
        it.exp = e;
        it.tag = tag;
        it.due = cyc + 1;
        q.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compare queued masks shortly after their due edge.
    always @(posedge clk) begin
        #2;
        while (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            it = q.pop_front();
            check(it.tag, 32'(mask_s[it.sel]), 32'(it.exp));
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 3; s++) begin
            map_s[s] = '0; we_s[s] = 1'b0; kind_s[s] = '0;
            dom_s[s] = '0; data_s[s] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 mask", 32'(mask_s[0]), 0);
        check("R11 prefix", 32'(pfx_s[0]), 0);
        check("R11 sealed", 32'(seal_s[0]), 0);
        check("R11 locked", 32'(lck_s[0]), 0);
        check("R11 stride", 32'(strd_s[2]), 3);

        // R1 bounded partition: tops 4,10,10,16,20,24
        wr(0, 0, 0, 4);  wr(0, 0, 1, 10); wr(0, 0, 2, 10);
        wr(0, 0, 3, 16); wr(0, 0, 4, 20); wr(0, 0, 5, 24);
        probe(0, 6'b000001, 24'h00000F, "R1 dom0");
        probe(0, 6'b000010, 24'h0003F0, "R1 dom1");
        probe(0, 6'b000100, 24'h000000, "R2 equal bound empty");
        probe(0, 6'b101010, 24'hF0FFF0, "R3 or of dom1 dom3 dom5");
        probe(0, 6'b000000, 24'h000000, "R3 empty map");
        probe(0, 6'b111111, 24'hFFFFFF, "R3 all domains");

        // R2 non-monotonic bound
        wr(0, 0, 3, 8);
        probe(0, 6'b001000, 24'h000000, "R2 lower bound empty");
        probe(0, 6'b011000, 24'h0FFC00, "R2 dom4 floor from max");

        // R7 / R8 / R9 prefix lock
        wr(0, 2, 0, 2);
        check("R8 prefix raise", 32'(pfx_s[0]), 2);
        wr(0, 0, 1, 12);
        probe(0, 6'b000010, 24'h0003F0, "R7 locked bound ignored");
        wr(0, 0, 2, 14);
        probe(0, 6'b000100, 24'h003C00, "R7 unlocked bound written");
        wr(0, 2, 0, 1);
        check("R8 smaller ignored", 32'(pfx_s[0]), 2);
        wr(0, 2, 0, 4);
        check("R8 larger taken", 32'(pfx_s[0]), 4);
        wr(0, 2, 0, 16'h8005);
        check("R9 seal set", 32'(seal_s[0]), 1);
        check("R9 sealing write prefix", 32'(pfx_s[0]), 5);
        wr(0, 2, 0, 6);
        check("R9 sealed ignores", 32'(pfx_s[0]), 5);
        wr(0, 3, 0, 1);
        check("R6 enable set", 32'(lck_s[0]), 1);
        wr(0, 3, 0, 0);
        check("R6 enable sticky", 32'(lck_s[0]), 1);

        // R4 fixed stride K=4
        check("R4 stride reads K-1", 32'(strd_s[1]), 3);
        probe(1, 6'b000100, 24'h000F00, "R4 dom2 block");
        wr(1, 1, 0, 1);
        check("R4 stride write ignored", 32'(strd_s[1]), 3);
        probe(1, 6'b000100, 24'h000F00, "R4 block unchanged");

        // R10 lock absent in stride modes
        wr(1, 2, 0, 16'h8003);
        check("R10 prefix zero", 32'(pfx_s[1]), 0);
        check("R10 sealed zero", 32'(seal_s[1]), 0);
        wr(1, 0, 0, 20);
        probe(1, 6'b000001, 24'h00000F, "R10 bound write ignored");

        // R5 programmable stride
        probe(2, 6'b000010, 24'h0000F0, "R5 reset stride");
        wr(2, 1, 0, 2);
        check("R5 stride loaded", 32'(strd_s[2]), 2);
        probe(2, 6'b000010, 24'h000038, "R5 k3 dom1");
        probe(2, 6'b100000, 24'h038000, "R5 k3 dom5");
        wr(2, 1, 0, 4);
        probe(2, 6'b100000, 24'h000000, "R5 k5 dom5 clipped out");
        probe(2, 6'b010000, 24'hF00000, "R5 k5 dom4 clipped");
        wr(2, 3, 0, 1);
        check("R6 prg enable", 32'(lck_s[2]), 1);
        wr(2, 1, 0, 0);
        check("R5 stride locked", 32'(strd_s[2]), 4);
        probe(2, 6'b010000, 24'hF00000, "R5 mask after locked write");

        repeat (2) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R3 pending=%0d exp=0", q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule